// File: doc/BRIEF.md
# Video Window Cropper

This block sits in a camera parallel-input path, between the sensor bus and the engine that writes frames to memory. A sample is accepted on every clock in which both `pix_hsync` and `pix_vsync` are high. The block counts columns within a line and lines within a frame. It forwards only the samples that fall inside a programmable rectangle. Because of this, a sensor that was set to a larger resolution than the frame buffer cannot make the writer store more data than the buffer holds.

Columns and rows are cropped independently. Each dimension has an inclusive minimum and maximum and its own enable. Counts are in raw bus samples, not pixels. For a format that spends two bus samples per pixel, software programs bounds that cover twice the pixel count. Bounds and enables written by software are copied into shadow registers when a frame starts. A change made during a frame therefore takes effect from the next frame.

The output stage holds one forwarded sample so that it can attach the line-end marker. It has two states:
- `EM_EMPTY`: no sample is held.
- `EM_HELD`: one sample is held.

It has three transitions:
- `capture`: from EMPTY to HELD, when a sample is forwarded.
- `replace`: from HELD to HELD, when another sample is forwarded. The held sample is sent out without a line-end marker.
- `flush`: from HELD to EMPTY, when the line ends. The held sample is sent out with the line-end marker.

A line end seen while in EMPTY leaves the state unchanged.

Top module: `vid_crop_top`

## Requirements
- R1: A write with `cfg_sel`=1 sets the column minimum from `cfg_wdata[15:0]` and the column maximum from `cfg_wdata[31:16]`. A write with `cfg_sel`=2 sets the row minimum and row maximum in the same bit positions.
- R2: A write with `cfg_sel`=0 sets the column-crop enable from bit 12 and the row-crop enable from bit 13. All other bits of that word are ignored.
- R3: The column index is 0 for the first sample of each line and rises by one per sample. A sample passes the column test when that test is disabled, or when min <= index <= max with both bounds inclusive.
- R4: The row index is 0 for the first line after `pix_vsync` rises and rises by one per line. The row test works like the column test.
- R5: A disabled dimension forwards every sample in that dimension until the line or the frame ends. A maximum beyond the line length likewise forwards up to the line end.
- R6: If the minimum is greater than the maximum in an enabled dimension, no sample is forwarded.
- R7: The column and row counters saturate at their all-ones value and never wrap. A long line therefore cannot enter the window a second time.
- R8: Bounds and enables are latched when `pix_vsync` rises. A write made during a frame does not change that frame but does apply to the next one.
- R9: `out_sof` is high together with the first forwarded sample of each frame.
- R10: Forwarded samples leave in order, one per `out_valid` pulse. `out_eol` is high with the last forwarded sample of each line. A sample is presented when the next forwarded sample arrives or when its line ends.
- R11: After reset, `out_valid`, `out_sof`, `out_eol` and `out_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 enables, 1 column bounds, 2 row bounds |
| cfg_wdata | input | 32 | Configuration write data |
| pix_data | input | DW | Sensor sample |
| pix_hsync | input | 1 | Line active, high during a line |
| pix_vsync | input | 1 | Frame active, high during a frame |
| out_data | output | DW | Forwarded sample |
| out_valid | output | 1 | Forwarded-sample strobe |
| out_sof | output | 1 | First forwarded sample of a frame |
| out_eol | output | 1 | Last forwarded sample of a line |

## Verification
A counter that does not restart or that wraps would show up as samples from the wrong columns, or as a second burst late in a line. The bench sees this in the forwarded count and data of the same frame, because each sample's data encodes its own row and column. A shadow copy loaded at the wrong time changes the window of the frame in which software writes, and this is visible before that frame ends. A wrong hold state shows up one sample later as a missing, duplicated or unmarked line end.

// File: rtl/vid_crop_pkg.sv
package vid_crop_pkg;
    typedef enum logic {EM_EMPTY = 1'b0, EM_HELD = 1'b1} emit_st_e;
    localparam logic [1:0] SEL_MAIN = 2'd0;
    localparam logic [1:0] SEL_COL  = 2'd1;
    localparam logic [1:0] SEL_ROW  = 2'd2;
    localparam int BIT_COL_EN = 12;
    localparam int BIT_ROW_EN = 13;
endpackage

// File: rtl/vid_crop_cfg.sv
module vid_crop_cfg
    import vid_crop_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [31:0]   wdata,
    input  logic          frame_start,
    output logic [1:0]    en,
    output logic [CW-1:0] lo [2],
    output logic [CW-1:0] hi [2]
);
    localparam logic [CW-1:0] ONES = '1;

    logic [1:0]    lv_en, sh_en;
    logic [CW-1:0] lv_lo [2];
    logic [CW-1:0] lv_hi [2];
    logic [CW-1:0] sh_lo [2];
    logic [CW-1:0] sh_hi [2];

    // software-visible (live) copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lv_en    <= '0;
            lv_lo[0] <= '0;
            lv_hi[0] <= ONES;
            lv_lo[1] <= '0;
            lv_hi[1] <= ONES;
        end else if (we) begin
            unique case (sel)
                SEL_MAIN: lv_en <= {wdata[BIT_ROW_EN], wdata[BIT_COL_EN]};
                SEL_COL: begin
                    lv_lo[0] <= wdata[CW-1:0];
                    lv_hi[0] <= wdata[16+CW-1:16];
                end
                SEL_ROW: begin
                    lv_lo[1] <= wdata[CW-1:0];
                    lv_hi[1] <= wdata[16+CW-1:16];
                end
                default: ;
            endcase
        end
    end

    // frame-stable (shadow) copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_en    <= '0;
            sh_lo[0] <= '0;
            sh_hi[0] <= ONES;
            sh_lo[1] <= '0;
            sh_hi[1] <= ONES;
        end else if (frame_start) begin
            sh_en <= lv_en;
            sh_lo <= lv_lo;
            sh_hi <= lv_hi;
        end
    end

    // the frame-start cycle already uses the values being latched
    always_comb begin
        en = frame_start ? lv_en : sh_en;
        lo = frame_start ? lv_lo : sh_lo;
        hi = frame_start ? lv_hi : sh_hi;
    end

    logic [4*CW+1:0] sh_all;
    assign sh_all = {sh_en, sh_lo[0], sh_hi[0], sh_lo[1], sh_hi[1]};

    a_r8_shadow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(sh_all));
endmodule

// File: rtl/vid_crop_ctr.sv
module vid_crop_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cur
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] cnt, nxt;

    always_comb begin
        cur = clr ? '0 : cnt;
        nxt = cur;
        if (inc && cur != TOP) nxt = cur + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == TOP && !clr) |=> cnt == TOP);
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && inc) |=> cnt == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/vid_crop_emit.sv
module vid_crop_emit
    import vid_crop_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwd,
    input  logic [DW-1:0] din,
    input  logic          frame_start,
    input  logic          line_end,
    output logic [DW-1:0] dout,
    output logic          dvalid,
    output logic          sof,
    output logic          eol
);
    emit_st_e      st, st_nx;
    logic [DW-1:0] hold_d;
    logic          hold_sof;
    logic          sof_pend;

    always_comb begin
        st_nx = st;
        unique case (st)
            EM_EMPTY: if (fwd) st_nx = EM_HELD;           // capture
            EM_HELD: begin
                if (fwd)           st_nx = EM_HELD;       // replace
                else if (line_end) st_nx = EM_EMPTY;      // flush
            end
            default: st_nx = EM_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= EM_EMPTY;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout     <= '0;
            dvalid   <= 1'b0;
            sof      <= 1'b0;
            eol      <= 1'b0;
            hold_d   <= '0;
            hold_sof <= 1'b0;
            sof_pend <= 1'b0;
        end else begin
            dvalid <= 1'b0;
            sof    <= 1'b0;
            eol    <= 1'b0;
            if (st == EM_HELD && (fwd || line_end)) begin
                dout   <= hold_d;
                dvalid <= 1'b1;
                sof    <= hold_sof;
                eol    <= !fwd;
            end
            if (fwd) begin
                hold_d   <= din;
                hold_sof <= sof_pend || frame_start;
                sof_pend <= 1'b0;
            end else if (frame_start) begin
                sof_pend <= 1'b1;
            end
        end
    end

    a_r10_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EM_EMPTY) |=> !dvalid);
    a_r10_flush_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (st == EM_HELD && line_end && !fwd) |=> (dvalid && eol));
    a_r9_marks_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sof || eol) |-> dvalid);
endmodule

// File: rtl/vid_crop_top.sv
module vid_crop_top #(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic [DW-1:0] pix_data,
    input  logic          pix_hsync,
    input  logic          pix_vsync,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_eol
);
    localparam int NDIM = 2;   // 0: columns, 1: rows

    logic vs_q, act_q, act;
    logic frame_start, line_start, line_end;
    logic [CW-1:0] row_line;

    logic [NDIM-1:0] win_en, dim_ok, ctr_clr, ctr_inc;
    logic [CW-1:0]   win_lo  [NDIM];
    logic [CW-1:0]   win_hi  [NDIM];
    logic [CW-1:0]   ctr_cur [NDIM];
    logic [CW-1:0]   idx     [NDIM];
    logic            fwd;

    assign act         = pix_hsync && pix_vsync;
    assign frame_start = pix_vsync && !vs_q;
    assign line_start  = act && !act_q;
    assign line_end    = !act && act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q     <= 1'b0;
            act_q    <= 1'b0;
            row_line <= '0;
        end else begin
            vs_q  <= pix_vsync;
            act_q <= act;
            if (line_start) row_line <= ctr_cur[1];
        end
    end

    vid_crop_cfg #(.CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .frame_start(frame_start),
        .en(win_en), .lo(win_lo), .hi(win_hi)
    );

    assign ctr_clr = {frame_start, line_start};
    assign ctr_inc = {line_start, act};
    assign idx[0]  = ctr_cur[0];
    assign idx[1]  = line_start ? ctr_cur[1] : row_line;

    for (genvar d = 0; d < NDIM; d++) begin : g_dim
        vid_crop_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(ctr_clr[d]),
            .inc(ctr_inc[d]), .cur(ctr_cur[d])
        );
        assign dim_ok[d] = !win_en[d] ||
                           (idx[d] >= win_lo[d] && idx[d] <= win_hi[d]);
    end

    assign fwd = act && (&dim_ok);

    vid_crop_emit #(.DW(DW)) u_emit (
        .clk(clk), .rst_n(rst_n), .fwd(fwd), .din(pix_data),
        .frame_start(frame_start), .line_end(line_end),
        .dout(out_data), .dvalid(out_valid), .sof(out_sof), .eol(out_eol)
    );

    a_r6_empty_window: assert property (@(posedge clk) disable iff (!rst_n)
        (win_en[0] && win_lo[0] > win_hi[0]) |-> !fwd);
    a_r5_idle_no_out: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && !act_q) |=> !out_valid);
endmodule

// File: tb/vid_crop_top_tb.sv
module vid_crop_top_tb;
    localparam int DW = 16;
    localparam int MAXQ = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [DW-1:0] pix_data = '0;
    logic pix_hsync = 1'b0, pix_vsync = 1'b0;
    logic [DW-1:0] out_data;
    logic out_valid, out_sof, out_eol;

    always #2 clk = ~clk;   // 250 MHz

    vid_crop_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pix_data(pix_data), .pix_hsync(pix_hsync),
        .pix_vsync(pix_vsync), .out_data(out_data), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol)
    );

    int nchk = 0, nfail = 0;
    logic [17:0] got [MAXQ];
    logic [17:0] exq [MAXQ];
    int got_n = 0, e_n = 0;

    always @(negedge clk) if (out_valid) begin
        if (got_n < MAXQ) got[got_n] = {out_sof, out_eol, out_data};
        got_n = got_n + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] v);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R2: bit 12 column enable, bit 13 row enable, every other bit set
    task automatic prog(input bit ce, input bit re, input int cmin, input int cmax,
                        input int rmin, input int rmax);
        cfg_write(2'd0, 32'hFFFF_CFFF | (32'(ce) << 12) | (32'(re) << 13));
        cfg_write(2'd1, {cmax[15:0], cmin[15:0]});   // R1
        cfg_write(2'd2, {rmax[15:0], rmin[15:0]});
    endtask

    task automatic build_exp(input bit ce, input bit re, input int cmin, input int cmax,
                             input int rmin, input int rmax, input int w, input int l);
        e_n = 0;
        for (int r = 0; r < l; r++) begin
            bit any = 1'b0;
            for (int c = 0; c < w; c++) begin
                bit ok = (!ce || (c >= cmin && c <= cmax)) &&
                         (!re || (r >= rmin && r <= rmax));
                if (ok && e_n < MAXQ) begin
                    exq[e_n] = {e_n == 0, 1'b0, r[7:0], c[7:0]};
                    e_n++;
                    any = 1'b1;
                end
            end
            if (any) exq[e_n-1][16] = 1'b1;
        end
    endtask

    task automatic run_frame(input int w, input int l, input bit mid,
                             input logic [31:0] midw);
        got_n = 0;
        pix_vsync = 1'b0; pix_hsync = 1'b0;
        repeat (4) @(negedge clk);
        pix_vsync = 1'b1;
        for (int r = 0; r < l; r++) begin
            repeat (3) @(negedge clk);
            if (mid && r == 1) cfg_write(2'd1, midw);
            pix_hsync = 1'b1;
            for (int c = 0; c < w; c++) begin
                pix_data = {r[7:0], c[7:0]};
                @(negedge clk);
            end
            pix_hsync = 1'b0;
        end
        repeat (2) @(negedge clk);
        pix_vsync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        int bad = -1;
        check(got_n == e_n, tag, "count", got_n, e_n);
        for (int i = 0; i < e_n && i < MAXQ; i++)
            if (bad < 0 && got[i] !== exq[i]) bad = i;
        check(bad < 0, tag, "sof,eol,data word", (bad < 0) ? 0 : int'(got[bad]),
              (bad < 0) ? 0 : int'(exq[bad]));
    endtask

    typedef struct packed {
        logic ce; logic re;
        logic [15:0] cmin; logic [15:0] cmax;
        logic [15:0] rmin; logic [15:0] rmax;
        logic [7:0] w; logic [7:0] l;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 1'b0, 16'd0, 16'd0,   16'd0, 16'd0,   8'd10, 8'd6}, // R5 R2 both off
        '{1'b1, 1'b0, 16'd2, 16'd5,   16'd0, 16'd0,   8'd10, 8'd6}, // R3 columns
        '{1'b0, 1'b1, 16'd0, 16'd0,   16'd1, 16'd3,   8'd10, 8'd6}, // R4 rows
        '{1'b1, 1'b1, 16'd0, 16'd0,   16'd0, 16'd0,   8'd10, 8'd6}, // R9 single sample
        '{1'b1, 1'b1, 16'd6, 16'd2,   16'd0, 16'd5,   8'd10, 8'd6}, // R6 min>max
        '{1'b1, 1'b1, 16'd7, 16'd200, 16'd4, 16'd100, 8'd10, 8'd6}, // R10 past end
        '{1'b1, 1'b1, 16'd0, 16'd9,   16'd5, 16'd5,   8'd10, 8'd6}  // R1 inclusive
    };
    string vtag [7] = '{"R5", "R3", "R4", "R9", "R6", "R10", "R1"};

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid === 1'b0 && out_sof === 1'b0 && out_eol === 1'b0,
              "R11", "markers", int'({out_valid, out_sof, out_eol}), 0);
        check(out_data === '0, "R11", "data", int'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 7; k++) begin
            vec_t v = VECS[k];
            prog(v.ce, v.re, int'(v.cmin), int'(v.cmax), int'(v.rmin), int'(v.rmax));
            build_exp(v.ce, v.re, int'(v.cmin), int'(v.cmax), int'(v.rmin),
                      int'(v.rmax), int'(v.w), int'(v.l));
            run_frame(int'(v.w), int'(v.l), 1'b0, 32'd0);
            compare(vtag[k]);
        end

        // R8: write in mid-frame applies only to the next frame
        prog(1'b1, 1'b0, 0, 1, 0, 0);
        build_exp(1'b1, 1'b0, 0, 1, 0, 0, 8, 4);
        run_frame(8, 4, 1'b1, {16'd6, 16'd5});
        compare("R8 current frame");
        build_exp(1'b1, 1'b0, 5, 6, 0, 0, 8, 4);
        run_frame(8, 4, 1'b0, 32'd0);
        compare("R8 next frame");

        // R7: a line longer than the counter range must not re-enter the window
        prog(1'b1, 1'b0, 0, 3, 0, 0);
        build_exp(1'b1, 1'b0, 0, 3, 0, 0, 65540, 1);
        run_frame(65540, 1, 1'b0, 32'd0);
        compare("R7");

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule